// File: doc/BRIEF.md
# Half-Duplex Deferral and Backoff Gate

This block decides the cycle in which a transmitter may begin sending a frame. A requester raises `framePend` and holds it until the frame has gone out; the block answers with `txGrant`, which stays high for the whole transmission. One clock stands for one bit time throughout.

Before every grant the block enforces an interframe gap in two phases. In the first phase it watches for a run of idle cycles, and in the second phase it counts down a fixed run of cycles that is already committed. With the default settings the two phases are 60 and 36 cycles, which gives the 96-bit-time gap. In half-duplex mode (`fullDuplex` low), carrier sense holds the first phase back and restarts it, and the second phase ignores carrier. In full-duplex mode carrier sense and the collision input are both ignored, and only the gap length applies.

When a collision arrives during a half-duplex grant, the block drops the grant. It then waits a random number of slot times before it runs a fresh gap and grants the same request again. The random range doubles with each collision up to a cap. Once the collisions on one frame exceed the programmed retry limit, the block pulses `retryExhausted` and abandons the frame. The requester is expected to withdraw `framePend` at that point.

Top module: `txStartGate`

## Requirements
- R1: While reset is asserted, `txGrant` and `retryExhausted` are low. After reset release the block is at the start of a gap, so a request held from release is granted at the WATCH_CYC+COMMIT_CYC-th rising edge and no earlier.
- R2: In half duplex, the watch phase needs WATCH_CYC consecutive edges that sample carrier low. An edge that samples carrier high during that phase restarts the count, so the grant follows WATCH_CYC+COMMIT_CYC idle edges after the last carrier-high edge.
- R3: Once the watch phase has completed, the next COMMIT_CYC edges finish the gap whatever carrier does. A pending request is granted at the edge that ends the commit phase.
- R4: In full duplex, carrier is ignored and a pending request is granted WATCH_CYC+COMMIT_CYC edges after the gap starts.
- R5: If the gap ends with no request pending, the block waits. A later request is granted at the next edge. In half duplex, carrier seen while waiting takes priority and restarts the whole gap.
- R6: `txGrant` stays high while `framePend` stays high and no counted collision occurs. The edge that samples `framePend` low ends the grant and starts a new gap.
- R7: A collision sampled while granted in half duplex drops the grant at that edge. The block then waits r*SLOT_CYC cycles and runs a full gap before it grants again. Here r is an integer drawn pseudo-randomly from 0 to 2^min(n,EXP_CAP)-1, and n is the number of collisions on the current frame.
- R8: In full duplex, the collision input has no effect on an active grant.
- R9: The collision that makes the count for the current frame exceed `retryLimit` raises `retryExhausted` for exactly one cycle, with `txGrant` low. That collision gets no backoff, and the next gap begins at once.
- R10: The collision count restarts at zero when a frame completes normally and when a frame is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| crsIn | input | 1 | Carrier sense from the line |
| colIn | input | 1 | Collision indication |
| fullDuplex | input | 1 | 1 selects full duplex, 0 selects half duplex |
| framePend | input | 1 | A frame is waiting or being sent; held until the frame is finished |
| retryLimit | input | LIMIT_W | Most retries allowed per frame (15 is typical) |
| txGrant | output | 1 | Transmission may proceed; held for the whole frame |
| retryExhausted | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
The gap is checked by placing a single carrier-high cycle at every position from the first watch cycle to beyond the end of the commit phase. This separates a restart of the watch phase from carrier being ignored in the commit phase, and the same sweep in full duplex shows that carrier has no effect there. Requests that arrive after the gap has ended, with and without carrier during the wait, separate the waiting behaviour from the gap itself. Chains of collisions against retry limits of 0 to 4 and of 15 are used to measure each backoff as a whole number of slots inside its doubling window, to place the exhausted pulse on the exact collision, and to show the count clearing between frames.

// File: rtl/txgate_pkg.sv
package txgate_pkg;

  typedef enum logic [2:0] {
    ST_WATCH,
    ST_COMMIT,
    ST_READY,
    ST_XMIT,
    ST_BACKOFF
  } gateState_t;

  typedef struct packed {
    logic clrGap;
    logic incGap;
    logic loadBackoff;
    logic stepBackoff;
    logic bumpAttempt;
    logic clrAttempt;
  } gateStrobe_t;

endpackage

// File: rtl/txGateDatapath.sv
module txGateDatapath
  import txgate_pkg::*;
#(
  parameter int WATCH_CYC  = 60,
  parameter int COMMIT_CYC = 36,
  parameter int SLOT_CYC   = 512,
  parameter int EXP_CAP    = 10,
  parameter int LIMIT_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStrobe_t        strobe,
  input  logic [LIMIT_W-1:0] retryLimit,
  output logic               watchDone,
  output logic               gapDone,
  output logic               bkLast,
  output logic               drawZero,
  output logic               overLimit
);

  localparam int GAP_W  = $clog2(WATCH_CYC + COMMIT_CYC);
  localparam int SLOT_W = $clog2(SLOT_CYC);
  localparam int ATT_W  = LIMIT_W + 1;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [GAP_W-1:0]  WATCH_LAST = GAP_W'(WATCH_CYC - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST   = GAP_W'(WATCH_CYC + COMMIT_CYC - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(SLOT_CYC - 1);

  logic [GAP_W-1:0]   gapCnt;
  logic [SLOT_W-1:0]  bitCnt;
  logic [EXP_CAP-1:0] slotCnt;
  logic [ATT_W-1:0]   attemptCnt;
  logic [ATT_W-1:0]   attNext;
  logic [LFSR_W-1:0]  lfsr;
  logic [EXP_CAP-1:0] drawMask;
  logic [EXP_CAP-1:0] drawSlots;

  function automatic int capOf(logic [ATT_W-1:0] a);
    int v;
    v = int'(a);
    return (v > EXP_CAP) ? EXP_CAP : v;
  endfunction

  // interframe gap counter shared by both phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (strobe.clrGap)   gapCnt <= '0;
    else if (strobe.incGap)   gapCnt <= gapCnt + 1'b1;
  end

  assign watchDone = (gapCnt == WATCH_LAST);
  assign gapDone   = (gapCnt == GAP_LAST);

  // free-running pseudo-random source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else       lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  // collision count of the current frame
  assign attNext   = attemptCnt + 1'b1;
  assign overLimit = attNext > {1'b0, retryLimit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   attemptCnt <= '0;
    else if (strobe.clrAttempt)  attemptCnt <= '0;
    else if (strobe.bumpAttempt) attemptCnt <= attNext;
  end

  // truncated exponential window for the coming retry
  always_comb begin
    int expK;
    expK = capOf(attNext);
    for (int i = 0; i < EXP_CAP; i++) drawMask[i] = (i < expK);
  end

  assign drawSlots = lfsr[EXP_CAP-1:0] & drawMask;
  assign drawZero  = (drawSlots == '0);

  // backoff slot and bit counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      bitCnt  <= '0;
    end else if (strobe.loadBackoff) begin
      slotCnt <= drawSlots;
      bitCnt  <= '0;
    end else if (strobe.stepBackoff) begin
      if (bitCnt == SLOT_LAST) begin
        bitCnt  <= '0;
        slotCnt <= slotCnt - 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign bkLast = (slotCnt == EXP_CAP'(1)) && (bitCnt == SLOT_LAST);

  AST_DRAW_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadBackoff) |-> ((int'(slotCnt) >> capOf(attemptCnt)) == 0)); // R7

  AST_STEP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepBackoff |-> (slotCnt != '0)); // R7

endmodule

// File: rtl/txGateControl.sv
module txGateControl
  import txgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        crsIn,
  input  logic        colIn,
  input  logic        fullDuplex,
  input  logic        framePend,
  input  logic        watchDone,
  input  logic        gapDone,
  input  logic        bkLast,
  input  logic        drawZero,
  input  logic        overLimit,
  output gateStrobe_t strobe,
  output logic        txGrant,
  output logic        retryExhausted
);

  gateState_t state, nxt;
  logic exhaustSet;
  logic carrierSeen;
  logic colCounted;

  assign carrierSeen = !fullDuplex && crsIn;
  assign colCounted  = !fullDuplex && colIn;

  always_comb begin
    nxt        = state;
    strobe     = '0;
    exhaustSet = 1'b0;
    unique case (state)
      ST_WATCH: begin
        if (carrierSeen) begin
          strobe.clrGap = 1'b1;
        end else begin
          strobe.incGap = 1'b1;
          if (watchDone) nxt = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        if (gapDone) nxt = framePend ? ST_XMIT : ST_READY;
        else         strobe.incGap = 1'b1;
      end
      ST_READY: begin
        strobe.clrGap = 1'b1;
        if (carrierSeen)    nxt = ST_WATCH;
        else if (framePend) nxt = ST_XMIT;
      end
      ST_XMIT: begin
        strobe.clrGap = 1'b1;
        if (colCounted) begin
          if (overLimit) begin
            strobe.clrAttempt = 1'b1;
            exhaustSet        = 1'b1;
            nxt               = ST_WATCH;
          end else begin
            strobe.bumpAttempt = 1'b1;
            if (drawZero) begin
              nxt = ST_WATCH;
            end else begin
              strobe.loadBackoff = 1'b1;
              nxt                = ST_BACKOFF;
            end
          end
        end else if (!framePend) begin
          strobe.clrAttempt = 1'b1;
          nxt               = ST_WATCH;
        end
      end
      ST_BACKOFF: begin
        strobe.clrGap      = 1'b1;
        strobe.stepBackoff = 1'b1;
        if (bkLast) nxt = ST_WATCH;
      end
      default: nxt = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_WATCH;
      txGrant        <= 1'b0;
      retryExhausted <= 1'b0;
    end else begin
      state          <= nxt;
      txGrant        <= (nxt == ST_XMIT);
      retryExhausted <= exhaustSet;
    end
  end

  AST_WATCH_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WATCH && !fullDuplex && crsIn) |=> (state == ST_WATCH)); // R2

  AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COMMIT && !gapDone) |=> (state == ST_COMMIT)); // R3

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txGrant) |-> $past(framePend)); // R5

  AST_FD_COL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (txGrant && fullDuplex && framePend) |=> txGrant); // R8

  AST_EXHAUST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    retryExhausted |=> !retryExhausted); // R9

  AST_EXHAUST_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    retryExhausted |-> !txGrant); // R9

endmodule

// File: rtl/txStartGate.sv
module txStartGate
  import txgate_pkg::*;
#(
  parameter int WATCH_CYC  = 60,
  parameter int COMMIT_CYC = 36,
  parameter int SLOT_CYC   = 512,
  parameter int EXP_CAP    = 10,
  parameter int LIMIT_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               crsIn,
  input  logic               colIn,
  input  logic               fullDuplex,
  input  logic               framePend,
  input  logic [LIMIT_W-1:0] retryLimit,
  output logic               txGrant,
  output logic               retryExhausted
);

  gateStrobe_t strobe;
  logic watchDone, gapDone, bkLast, drawZero, overLimit;

  txGateControl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .crsIn          (crsIn),
    .colIn          (colIn),
    .fullDuplex     (fullDuplex),
    .framePend      (framePend),
    .watchDone      (watchDone),
    .gapDone        (gapDone),
    .bkLast         (bkLast),
    .drawZero       (drawZero),
    .overLimit      (overLimit),
    .strobe         (strobe),
    .txGrant        (txGrant),
    .retryExhausted (retryExhausted)
  );

  txGateDatapath #(
    .WATCH_CYC  (WATCH_CYC),
    .COMMIT_CYC (COMMIT_CYC),
    .SLOT_CYC   (SLOT_CYC),
    .EXP_CAP    (EXP_CAP),
    .LIMIT_W    (LIMIT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .retryLimit (retryLimit),
    .watchDone  (watchDone),
    .gapDone    (gapDone),
    .bkLast     (bkLast),
    .drawZero   (drawZero),
    .overLimit  (overLimit)
  );

endmodule

// File: tb/txStartGate_tb_top.sv
module txStartGate_tb_top;

  localparam int W   = 6;
  localparam int C   = 4;
  localparam int S   = 8;
  localparam int CAP = 3;
  localparam int LW  = 4;
  localparam int GAP = W + C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic crsIn = 1'b0;
  logic colIn = 1'b0;
  logic fullDuplex = 1'b0;
  logic framePend = 1'b0;
  logic [LW-1:0] retryLimit = 4'd15;
  logic txGrant, retryExhausted;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  txStartGate #(
    .WATCH_CYC(W), .COMMIT_CYC(C), .SLOT_CYC(S), .EXP_CAP(CAP), .LIMIT_W(LW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .crsIn(crsIn), .colIn(colIn),
    .fullDuplex(fullDuplex), .framePend(framePend), .retryLimit(retryLimit),
    .txGrant(txGrant), .retryExhausted(retryExhausted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // ends at a falling edge with reset just released; inputs idle
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; colIn = 1'b0; framePend = 1'b0; crsIn = 1'b0;
    @(negedge clk);
    check(txGrant == 1'b0, "R1 grant in reset", int'(txGrant), 0);
    check(retryExhausted == 1'b0, "R1 exhausted in reset", int'(retryExhausted), 0);
    rstN = 1'b1;
  endtask

  task automatic waitGrant(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!txGrant && n < 2000);
  endtask

  task automatic collide(output int lowLen, output bit exh);
    colIn = 1'b1;
    @(negedge clk);
    colIn = 1'b0;
    exh = retryExhausted;
    lowLen = 0;
    if (exh) begin
      check(txGrant == 1'b0, "R9 grant low on exhaust", int'(txGrant), 0);
      return;
    end
    while (!txGrant && lowLen < 2000) begin
      lowLen++;
      @(negedge clk);
    end
  endtask

  task automatic gapRun(input bit fd, input int p);
    int got;
    int exp;
    doReset();
    fullDuplex = fd;
    framePend = 1'b1;
    crsIn = (p == 0);
    got = -1;
    for (int k = 1; k < 300; k++) begin
      @(negedge clk);
      if (txGrant) begin
        got = k;
        break;
      end
      crsIn = (k == p);
    end
    crsIn = 1'b0;
    if (fd) exp = GAP;
    else    exp = (p < W) ? p + 1 + GAP : GAP;
    if (fd)          check(got == exp, "R4 full-duplex gap", got, exp);
    else if (p < W)  check(got == exp, "R2 watch restart", got, exp);
    else             check(got == exp, "R3 commit ignores carrier", got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int n, lowLen, r, maxR, lim, hiCnt;
    bit exh;

    // R1: request held from reset release
    doReset();
    framePend = 1'b1;
    waitGrant(n);
    check(n == GAP, "R1 first grant latency", n, GAP);

    // R6: grant held, then frame end starts a new gap
    hiCnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (txGrant) hiCnt++;
    end
    check(hiCnt == 6, "R6 grant held during frame", hiCnt, 6);
    framePend = 1'b0;
    @(negedge clk);
    check(txGrant == 1'b0, "R6 grant ends with request", int'(txGrant), 0);
    framePend = 1'b1;
    waitGrant(n);
    check(n == GAP, "R6 gap after frame end", n, GAP);

    // R2, R3, R4: carrier pulse swept over every gap position
    for (int p = 0; p <= GAP; p++) gapRun(1'b0, p);
    for (int p = 0; p <= GAP; p++) gapRun(1'b1, p);

    // R5: request arriving after the gap
    doReset();
    fullDuplex = 1'b0;
    hiCnt = 0;
    for (int i = 0; i < GAP + 5; i++) begin
      @(negedge clk);
      if (txGrant) hiCnt++;
    end
    check(hiCnt == 0, "R5 no grant without request", hiCnt, 0);
    framePend = 1'b1;
    waitGrant(n);
    check(n == 1, "R5 late request granted next edge", n, 1);

    doReset();
    fullDuplex = 1'b0;
    repeat (GAP + 3) @(negedge clk);
    crsIn = 1'b1; framePend = 1'b1;
    @(negedge clk);
    check(txGrant == 1'b0, "R5 carrier wins while waiting", int'(txGrant), 0);
    crsIn = 1'b0;
    waitGrant(n);
    check(n == GAP, "R5 carrier restarts gap", n, GAP);

    doReset();
    fullDuplex = 1'b1;
    repeat (GAP + 3) @(negedge clk);
    crsIn = 1'b1; framePend = 1'b1;
    waitGrant(n);
    crsIn = 1'b0;
    check(n == 1, "R5 full duplex ignores carrier while waiting", n, 1);

    // R8: collisions ignored in full duplex
    hiCnt = 0;
    for (int i = 0; i < 4; i++) begin
      colIn = 1'b1;
      @(negedge clk);
      colIn = 1'b0;
      for (int j = 0; j < 3; j++) begin
        if (txGrant && !retryExhausted) hiCnt++;
        @(negedge clk);
      end
    end
    check(hiCnt == 12, "R8 grant kept through collisions", hiCnt, 12);

    // R7, R9: backoff windows up to the limit of 15
    doReset();
    fullDuplex = 1'b0;
    retryLimit = 4'd15;
    framePend = 1'b1;
    waitGrant(n);
    maxR = 0;
    for (int c = 1; c <= 15; c++) begin
      collide(lowLen, exh);
      check(!exh, "R9 no exhaust within limit", int'(exh), 0);
      check(lowLen >= GAP && ((lowLen - GAP) % S) == 0, "R7 backoff whole slots", lowLen, GAP);
      r = (lowLen - GAP) / S;
      if (r > maxR) maxR = r;
      check(r < (1 << ((c > CAP) ? CAP : c)), "R7 backoff window", r, (1 << ((c > CAP) ? CAP : c)) - 1);
    end
    check(maxR > 0, "R7 nonzero backoff drawn", maxR, 1);
    collide(lowLen, exh);
    check(exh, "R9 exhaust on sixteenth collision", int'(exh), 1);
    framePend = 1'b0;
    @(negedge clk);
    check(retryExhausted == 1'b0, "R9 exhaust one cycle", int'(retryExhausted), 0);
    hiCnt = 0;
    for (int i = 0; i < GAP + 4; i++) begin
      @(negedge clk);
      if (txGrant) hiCnt++;
    end
    check(hiCnt == 0, "R9 frame dropped", hiCnt, 0);

    // R9, R10: limit sweep, count cleared after abandon
    for (lim = 0; lim <= 4; lim++) begin
      doReset();
      retryLimit = LW'(lim);
      framePend = 1'b1;
      waitGrant(n);
      for (int c = 1; c <= lim + 1; c++) begin
        collide(lowLen, exh);
        check(exh == (c == lim + 1), "R9 exhaust position", int'(exh), int'(c == lim + 1));
      end
      framePend = 1'b0;
      @(negedge clk);
      framePend = 1'b1;
      waitGrant(n);
      collide(lowLen, exh);
      check(exh == (lim == 0), "R10 count cleared after abandon", int'(exh), int'(lim == 0));
      framePend = 1'b0;
      @(negedge clk);
    end

    // R10: count cleared after a normally completed frame
    doReset();
    retryLimit = 4'd2;
    framePend = 1'b1;
    waitGrant(n);
    for (int c = 1; c <= 2; c++) begin
      collide(lowLen, exh);
      check(!exh, "R10 first frame retries", int'(exh), 0);
    end
    framePend = 1'b0;
    @(negedge clk);
    framePend = 1'b1;
    waitGrant(n);
    for (int c = 1; c <= 3; c++) begin
      collide(lowLen, exh);
      check(exh == (c == 3), "R10 count restarts per frame", int'(exh), int'(c == 3));
    end
    framePend = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule